// File: doc/BRIEF.md
# Companding ADC Conversion Sequencer

This block is the digital controller of a segmented mu-law encoder built around a binary-weighted capacitor array, a 32-tap resistor string and one comparator. Each frame strobe launches one conversion. The sequencer drives the lower-plate switch of every capacitor, the input switch that keeps the top plates on the signal, and the resistor-string tap selection. After each switching step it waits a fixed settling window and then reads the comparator.

A conversion runs in a fixed order. First the array acquires the input and the comparator gives the polarity. The plates are then set to the start position for that polarity. The chord (segment) is found by a linear search that moves one capacitor per step, smallest first. The four step bits are then resolved by binary search on the resistor-string tap that drives the capacitor where the search stopped. A single reference serves both polarities: a negative input reverses the direction in which the plates move, and the sequencer inverts its reading of the comparator, so the same decision logic handles both signs.

When the word is complete the sequencer presents the 8-bit code together with a one-cycle done pulse, then waits for the next strobe. One conversion takes far less than a 125 µs frame at any usual clock.

Top module: `companding_adc_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0 and pcm_o is 0. Every cap_ref_o bit is 1 (reference position), cap_tap_o is 0, sa_on_o is 1 and tap_sel_o is 0.
- R2: A conversion starts only when frame_strobe is sampled high while the block is idle. A strobe seen during a conversion has no effect on its result or timing, and it does not start a second conversion.
- R3: During the acquire phase every plate is at the reference position (cap_ref_o all 1) and sa_on_o is 1. The comparator level sampled at the end of that phase is the sign: 1 means positive.
- R4: After the sign is known, a positive input puts every plate at ground (cap_ref_o all 0) with sa_on_o at 1. A negative input leaves every plate at reference and drives sa_on_o to 0.
- R5: The chord search switches capacitors in index order from 0 upward, one more per step. A positive search moves a plate from ground to reference, and a negative search moves it from reference to ground. The effective comparison is the comparator level for a positive sign and its inverse for a negative sign. The search stops when the effective comparison reads 0.
- R6: The chord equals the index of the capacitor whose switching made the effective comparison read 0. If capacitors 0 through N_CAPS-2 are all switched without that happening, the chord saturates at N_CAPS-1 (7).
- R7: During step resolution exactly one cap_tap_o bit is set, the one at the chord index. Capacitors below the chord index stay switched and those above it stay unswitched. tap_sel_o equals 2*trial+1. Trial bits are set MSB first, and each is kept when the effective comparison reads 1.
- R8: pcm_o is {sign, chord[2:0], step[3:0]} with the sign at bit 7. It changes only in the cycle where done_o is high, and done_o is high for exactly one cycle.
- R9: done_o rises SETTLE*(6+n)+1 clock edges after the edge that samples the strobe, where n = chord+1 for chords below 7 and n = 7 for chord 7.
- R10: Outside the acquire-to-sign transition and the step-resolution phase, the plate switches change in at most one capacitor between consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strobe | input | 1 | Frame start request |
| cmp_i | input | 1 | Comparator output, 1 when the array node is above the threshold |
| cap_ref_o | output | N_CAPS | Per-capacitor lower plate: 1 = reference, 0 = ground |
| cap_tap_o | output | N_CAPS | Per-capacitor lower plate on the resistor string (one-hot) |
| sa_on_o | output | 1 | Input sampling switch closed |
| tap_sel_o | output | STEP_BITS+1 | Resistor-string tap index |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse marking a new code |
| pcm_o | output | 1+log2(N_CAPS)+STEP_BITS | Code word {sign, chord, step} |

## Verification
The assertions check four things on every cycle. During the chord search only one plate moves per step. The string connection is never on more than one capacitor and is active only while the block is busy. The done pulse lasts one cycle, and the code changes only with it. The bench's scenarios cover what depends on the comparator's history: the sign decision, where the chord search stops (including saturation at 7), the resolved step bits for both polarities, the plate pattern while the tap drives the found capacitor, the exact latency for each chord length, and a strobe arriving mid-conversion.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_SIGN,
    ST_CHORD,
    ST_STEP,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/cas_settle_timer.sv
module cas_settle_timer #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cas_chord_unit.sv
module cas_chord_unit #(
  parameter int N_CAPS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       eval,
  input  logic                       eff,
  output logic [$clog2(N_CAPS)-1:0]  idx_o,
  output logic [$clog2(N_CAPS)-1:0]  chord_o,
  output logic                       found_o
);
  localparam int CHORD_W = $clog2(N_CAPS);
  localparam logic [CHORD_W-1:0] LAST_IDX = CHORD_W'(N_CAPS - 2);
  localparam logic [CHORD_W-1:0] SAT_VAL  = CHORD_W'(N_CAPS - 1);

  logic [CHORD_W-1:0] idx_q;
  logic [CHORD_W-1:0] chord_q;
  logic               at_last;

  assign at_last = (idx_q == LAST_IDX);
  assign found_o = eval && (!eff || at_last);
  assign idx_o   = idx_q;
  assign chord_o = chord_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      chord_q <= '0;
    end else if (clear) begin
      idx_q   <= '0;
      chord_q <= '0;
    end else if (eval) begin
      if (!eff) begin
        chord_q <= idx_q;
      end else if (at_last) begin
        chord_q <= SAT_VAL;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cas_sar_unit.sv
module cas_sar_unit #(
  parameter int BITS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            eval,
  input  logic            eff,
  output logic [BITS-1:0] trial_o,
  output logic [BITS-1:0] result_o,
  output logic            last_o
);
  logic [BITS-1:0] res_q;
  logic [BITS-1:0] mask_q;

  assign trial_o  = res_q | mask_q;
  assign result_o = res_q;
  assign last_o   = mask_q[0];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      res_q  <= '0;
      mask_q <= {1'b1, {(BITS-1){1'b0}}};
    end else if (eval) begin
      if (eff) begin
        res_q <= res_q | mask_q;
      end
      mask_q <= mask_q >> 1;
    end
  end
endmodule

// File: rtl/cas_plate_drive.sv
module cas_plate_drive #(
  parameter int N_CAPS    = 8,
  parameter int STEP_BITS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hold_ref,
  input  logic                       sign,
  input  logic [$clog2(N_CAPS):0]    nsw,
  input  logic                       tap_en,
  input  logic [$clog2(N_CAPS)-1:0]  tap_idx,
  input  logic [STEP_BITS:0]         tap_code,
  output logic [N_CAPS-1:0]          cap_ref_o,
  output logic [N_CAPS-1:0]          cap_tap_o,
  output logic                       sa_on_o,
  output logic [STEP_BITS:0]         tap_sel_o
);
  localparam int NSW_W = $clog2(N_CAPS) + 1;

  logic [N_CAPS-1:0] ref_d;
  logic [N_CAPS-1:0] tap_d;

  for (genvar gi = 0; gi < N_CAPS; gi++) begin : g_cap
    logic switched;
    assign switched  = (NSW_W'(gi) < nsw);
    assign tap_d[gi] = tap_en && (tap_idx == ($clog2(N_CAPS))'(gi));
    assign ref_d[gi] = hold_ref  ? 1'b1 :
                       tap_d[gi] ? 1'b0 :
                       (sign ? switched : !switched);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_ref_o <= '1;
      cap_tap_o <= '0;
      sa_on_o   <= 1'b1;
      tap_sel_o <= '0;
    end else begin
      cap_ref_o <= ref_d;
      cap_tap_o <= tap_d;
      sa_on_o   <= hold_ref ? 1'b1 : sign;
      tap_sel_o <= tap_en ? tap_code : '0;
    end
  end
endmodule

// File: rtl/companding_adc_seq.sv
module companding_adc_seq
  import cas_pkg::*;
#(
  parameter int N_CAPS    = 8,
  parameter int STEP_BITS = 4,
  parameter int SETTLE    = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  frame_strobe,
  input  logic                                  cmp_i,
  output logic [N_CAPS-1:0]                     cap_ref_o,
  output logic [N_CAPS-1:0]                     cap_tap_o,
  output logic                                  sa_on_o,
  output logic [STEP_BITS:0]                    tap_sel_o,
  output logic                                  busy_o,
  output logic                                  done_o,
  output logic [$clog2(N_CAPS)+STEP_BITS:0]     pcm_o
);
  localparam int CHORD_W = $clog2(N_CAPS);
  localparam int NSW_W   = CHORD_W + 1;
  localparam int PCM_W   = 1 + CHORD_W + STEP_BITS;

  seq_state_e           state_q;
  logic                 sign_q;
  logic                 done_q;
  logic [PCM_W-1:0]     pcm_q;

  logic                 expire;
  logic                 eff;
  logic [CHORD_W-1:0]   chord_idx;
  logic [CHORD_W-1:0]   chord_val;
  logic                 chord_found;
  logic [STEP_BITS-1:0] sar_trial;
  logic [STEP_BITS-1:0] sar_res;
  logic                 sar_last;
  logic [NSW_W-1:0]     nsw;
  logic                 timer_run;

  assign timer_run = (state_q == ST_SAMPLE) || (state_q == ST_SIGN) ||
                     (state_q == ST_CHORD)  || (state_q == ST_STEP);
  // negative inputs read the comparator inverted
  assign eff = cmp_i ^ ~sign_q;

  always_comb begin
    unique case (state_q)
      ST_CHORD: nsw = NSW_W'(chord_idx) + 1'b1;
      ST_STEP:  nsw = NSW_W'(chord_val);
      default:  nsw = '0;
    endcase
  end

  cas_settle_timer #(.SETTLE(SETTLE)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .run    (timer_run),
    .expire (expire)
  );

  cas_chord_unit #(.N_CAPS(N_CAPS)) chord_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (state_q == ST_SIGN),
    .eval    ((state_q == ST_CHORD) && expire),
    .eff     (eff),
    .idx_o   (chord_idx),
    .chord_o (chord_val),
    .found_o (chord_found)
  );

  cas_sar_unit #(.BITS(STEP_BITS)) sar_i (
    .clk      (clk),
    .rst      (rst),
    .clear    (state_q == ST_CHORD),
    .eval     ((state_q == ST_STEP) && expire),
    .eff      (eff),
    .trial_o  (sar_trial),
    .result_o (sar_res),
    .last_o   (sar_last)
  );

  cas_plate_drive #(.N_CAPS(N_CAPS), .STEP_BITS(STEP_BITS)) drive_i (
    .clk       (clk),
    .rst       (rst),
    .hold_ref  ((state_q == ST_IDLE) || (state_q == ST_SAMPLE) || (state_q == ST_FIN)),
    .sign      (sign_q),
    .nsw       (nsw),
    .tap_en    (state_q == ST_STEP),
    .tap_idx   (chord_val),
    .tap_code  ({sar_trial, 1'b1}),
    .cap_ref_o (cap_ref_o),
    .cap_tap_o (cap_tap_o),
    .sa_on_o   (sa_on_o),
    .tap_sel_o (tap_sel_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sign_q  <= 1'b0;
      done_q  <= 1'b0;
      pcm_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE:   if (frame_strobe) state_q <= ST_SAMPLE;
        ST_SAMPLE: if (expire) begin
                     sign_q  <= cmp_i;
                     state_q <= ST_SIGN;
                   end
        ST_SIGN:   if (expire) state_q <= ST_CHORD;
        ST_CHORD:  if (chord_found) state_q <= ST_STEP;
        ST_STEP:   if (expire && sar_last) state_q <= ST_FIN;
        ST_FIN: begin
          pcm_q   <= {sign_q, chord_val, sar_res};
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign pcm_o  = pcm_q;
endmodule

// File: rtl/cas_checker.sv
module cas_checker #(
  parameter int N_CAPS    = 8,
  parameter int STEP_BITS = 4
) (
  input logic                              clk,
  input logic                              rst,
  input logic [N_CAPS-1:0]                 cap_ref_o,
  input logic [N_CAPS-1:0]                 cap_tap_o,
  input logic                              sa_on_o,
  input logic                              busy_o,
  input logic                              done_o,
  input logic [$clog2(N_CAPS)+STEP_BITS:0] pcm_o
);
  // R10: one plate per step outside the acquire-to-sign move and the tap phase
  p_one_plate_per_step_r10: assert property (@(posedge clk) disable iff (rst)
    ((cap_tap_o == '0) && ($past(cap_tap_o) == '0) &&
     !($past(sa_on_o) && (&$past(cap_ref_o))))
    |-> ($countones(cap_ref_o ^ $past(cap_ref_o)) <= 1));

  // R7: string drives at most one capacitor
  p_tap_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cap_tap_o));

  // R7: string connection only during a conversion
  p_tap_only_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (cap_tap_o != '0) |-> busy_o);

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: code word moves only with done
  p_pcm_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    (pcm_o != $past(pcm_o)) |-> done_o);
endmodule

bind companding_adc_seq cas_checker #(.N_CAPS(N_CAPS), .STEP_BITS(STEP_BITS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cap_ref_o (cap_ref_o),
  .cap_tap_o (cap_tap_o),
  .sa_on_o   (sa_on_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .pcm_o     (pcm_o)
);

// File: tb/companding_adc_seq_tb_top.sv
module companding_adc_seq_tb_top;
  localparam int N_CAPS = 8;
  localparam int SB     = 4;
  localparam int S      = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_strobe = 1'b0;
  logic          cmp;
  logic [N_CAPS-1:0] cap_ref, cap_tap;
  logic          sa_on;
  logic [SB:0]   tap_sel;
  logic          busy, done;
  logic [7:0]    pcm;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // analog model
  logic       pos_t = 1'b1;
  int         chord_t = 0;
  int         step_t  = 0;

  always #4 clk = ~clk;

  companding_adc_seq #(.N_CAPS(N_CAPS), .STEP_BITS(SB), .SETTLE(S)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .frame_strobe (frame_strobe),
    .cmp_i        (cmp),
    .cap_ref_o    (cap_ref),
    .cap_tap_o    (cap_tap),
    .sa_on_o      (sa_on),
    .tap_sel_o    (tap_sel),
    .busy_o       (busy),
    .done_o       (done),
    .pcm_o        (pcm)
  );

  always_comb begin
    logic above;
    int   nsw;
    if (sa_on && (&cap_ref)) begin
      cmp = pos_t;
    end else if (|cap_tap) begin
      above = (int'(tap_sel) <= 2*step_t + 1);
      cmp = pos_t ? above : !above;
    end else begin
      nsw = pos_t ? $countones(cap_ref) : $countones(~cap_ref);
      above = (nsw <= chord_t);
      cmp = pos_t ? above : !above;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic run_conv(input bit pos, input int ch, input int st, input bit inject);
    int n = 0;
    bit got = 0;
    int bad_plate = 0;
    int tap_seen = 0;
    int ncs;
    int lat;
    int extra = 0;
    logic [7:0] exp_word;
    pos_t = pos; chord_t = ch; step_t = st;
    ncs = (ch < 7) ? ch + 1 : 7;
    lat = S * (6 + ncs) + 1;
    exp_word = {pos, 3'(ch), 4'(st)};
    @(negedge clk); frame_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk); frame_strobe = 1'b0;
    // R3: acquire phase plates
    chk(&cap_ref && sa_on && busy, "R3", "acquire plates all ref, SA on", int'(cap_ref), 255);
    while (!got && n < 300) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == S + 1) begin
        // R4: plate start position after sign
        if (pos) chk(cap_ref == '0 && sa_on, "R4", "positive start plates", int'(cap_ref), 0);
        else     chk(&cap_ref && !sa_on, "R4", "negative start plates/SA", int'({sa_on, cap_ref}), 255);
      end
      if (inject && n == 5) frame_strobe = 1'b1;
      if (inject && n == 6) frame_strobe = 1'b0;
      if (|cap_tap) begin
        tap_seen++;
        if (cap_tap != (N_CAPS'(1) << ch)) bad_plate++;
        for (int i = 0; i < N_CAPS; i++) begin
          if (i != ch && cap_ref[i] != (pos ? (i < ch) : !(i < ch))) bad_plate++;
        end
        if (tap_sel[0] != 1'b1) bad_plate++;
      end
      if (done) got = 1;
    end
    chk(bad_plate == 0 && tap_seen > 0, "R7", "plates during step phase", bad_plate, 0);
    chk(n == lat, inject ? "R2" : "R9", "done latency", n, lat);
    chk(pcm == exp_word, (ch == 7) ? "R6" : "R8", "code word", int'(pcm), int'(exp_word));
    @(posedge clk); @(negedge clk);
    chk(!done, "R8", "done width one cycle", int'(done), 0);
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); @(negedge clk);
      if (done || busy) extra++;
    end
    chk(extra == 0 && pcm == exp_word, "R2", "no second conversion", extra, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && pcm == 0, "R1", "reset status", int'({busy, done, pcm}), 0);
    chk(&cap_ref && cap_tap == 0 && sa_on && tap_sel == 0, "R1", "reset plates",
        int'({cap_tap, cap_ref}), 255);
  endtask

  task automatic t_positive_mid();      run_conv(1'b1, 3, 9, 1'b0);  endtask // R5 R8 R9
  task automatic t_negative_mid();      run_conv(1'b0, 5, 6, 1'b0);  endtask // R5 R7
  task automatic t_positive_smallest(); run_conv(1'b1, 0, 0, 1'b0);  endtask // R6 chord 0
  task automatic t_negative_saturate(); run_conv(1'b0, 7, 15, 1'b0); endtask // R6 saturation
  task automatic t_positive_saturate(); run_conv(1'b1, 7, 0, 1'b0);  endtask // R6
  task automatic t_strobe_while_busy(); run_conv(1'b1, 2, 10, 1'b1); endtask // R2
  task automatic t_negative_zero();     run_conv(1'b0, 0, 15, 1'b0); endtask // R3 sign 0

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_positive_mid();
    t_negative_mid();
    t_positive_smallest();
    t_negative_saturate();
    t_positive_saturate();
    t_strobe_while_busy();
    t_negative_zero();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule